// File: doc/BRIEF.md
# Fractional Serial Clock Generator

This block derives a serial-bus clock (SCK) from a fast reference clock. Each reference cycle it adds a programmable increment to an 11-bit phase accumulator, and it moves SCK at two points of the 2048-unit period. SCK leaves its idle level when the running sum reaches 1024. It returns to idle when the sum reaches 2048. The average SCK rate is therefore reference × increment / 2048. A host normally programs the increment as ceil(2048 / ceil(ref_hz / target_hz)).

The block holds several profiles. Each profile has:
- its own increment;
- a rate-doubling bit;
- a bit that clears the phase on a loop-restart pulse;
- two edge-direction bits, one for launching data and one for sampling data.

Two global controls apply to all profiles: clock polarity (the SCK idle level), and a gate that stops the clock while no slave select is active. The outputs are the SCK pin level plus one-cycle launch and sample strobes, which a shift engine uses to move data.

The sequencer has three states:
- `GEN_IDLE`: stopped, phase zero.
- `GEN_LOW`: first half of the period, SCK at idle.
- `GEN_HIGH`: second half of the period, SCK active.

Its transitions are:
- *start*: `GEN_IDLE`→`GEN_LOW`, or straight to `GEN_HIGH` when the first sum already reaches 1024.
- *lead*: `GEN_LOW`→`GEN_HIGH` when the sum reaches 1024.
- *trail*: `GEN_HIGH`→`GEN_LOW` when the sum reaches 2048.
- *restart*: any running state →`GEN_LOW` with the accumulator cleared.
- *stop*: any state →`GEN_IDLE` when the generator is not running.

Top module: `sckgen_top`

## Requirements
- R1: While reset is asserted, `sck_o` equals `cpol_i`, and `launch_o` and `sample_o` are 0.
- R2: The effective increment is derived from the selected profile's increment, doubled when that profile's double-rate bit is set. Running from a stopped state for N reference cycles with this increment e, SCK changes level exactly floor(N·e/1024) times. Each change occurs at the clock edge where the running sum first reaches the next multiple of 1024.
- R3: With an effective increment of zero, SCK stays at its idle level and no strobe is issued.
- R4: An effective increment above 1024 (including any raw value of 2048 or more) is limited to 1024, so SCK toggles on every reference cycle.
- R5: When `run_i` is 0, the accumulator is held at zero and SCK rests at `cpol_i` from the next edge on, with no strobes. On resuming, the period starts from phase zero.
- R6: When `gate_idle_i` is 1 and `ss_active_i` is 0, the generator behaves as stopped (R5). When `gate_idle_i` is 0, `ss_active_i` has no effect.
- R7: A `restart_i` pulse while running, with the selected profile's reset bit set, returns SCK to idle and the accumulator to zero at the next edge, without strobes. With the reset bit clear, the pulse has no effect on SCK or the strobes.
- R8: A rising SCK edge is one that goes 0→1. `launch_o` pulses for one cycle together with each SCK edge whose direction is rising when the selected profile's launch bit is 1, and falling when it is 0. `sample_o` follows the same rule using the latch bit. When both bits are equal, both strobes pulse in the same cycle.
- R9: `sck_o` equals `cpol_i` during the first half of the period (and while stopped), and equals its inverse during the second half.
- R10: Profile p occupies bits [16p+15:16p] of `prof_inc_i` and bit p of each per-profile bit vector. The profile chosen by `sel_i` alone controls the increment, doubling, restart reset and edge choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Generator enable |
| restart_i | input | 1 | Loop-restart pulse |
| ss_active_i | input | 1 | Some slave select is asserted |
| cpol_i | input | 1 | SCK idle level |
| gate_idle_i | input | 1 | Stop clock when no slave is selected |
| sel_i | input | SEL_W | Active profile index |
| prof_inc_i | input | NPROF·FREQ_W | Per-profile increments |
| prof_dbl_i | input | NPROF | Per-profile double-rate bit |
| prof_arst_i | input | NPROF | Per-profile clear-on-restart bit |
| prof_launch_rise_i | input | NPROF | Per-profile launch-on-rising bit |
| prof_latch_rise_i | input | NPROF | Per-profile sample-on-rising bit |
| sck_o | output | 1 | Serial clock level |
| launch_o | output | 1 | Launch strobe |
| sample_o | output | 1 | Sample strobe |

## Verification
A restart pulse or a gating stop can land in the same cycle that an SCK edge would otherwise occur. In that case the clear must win: no strobe, SCK at idle. The sweep places a restart pulse and a five-cycle slave-deselect window at fixed cycles across every increment, so for some increments these collide with edges. A cycle-level arithmetic model in the bench judges each cycle. The launch and sample strobes also coincide whenever the two edge bits are equal; all four bit combinations are swept, and both strobes are compared every cycle.

// File: rtl/sckgen_pkg.sv
package sckgen_pkg;
    typedef enum logic [1:0] {
        GEN_IDLE = 2'd0,
        GEN_LOW  = 2'd1,
        GEN_HIGH = 2'd2
    } gen_state_e;

    typedef struct packed {
        logic launch_rise;
        logic latch_rise;
    } edge_sel_t;
endpackage

// File: rtl/sckgen_prof_sel.sv
module sckgen_prof_sel
    import sckgen_pkg::*;
#(
    parameter int NPROF   = 2,
    parameter int FREQ_W  = 16,
    parameter int PHASE_W = 11,
    parameter int SEL_W   = 1
) (
    input  logic [NPROF*FREQ_W-1:0] prof_inc_i,
    input  logic [NPROF-1:0]        prof_dbl_i,
    input  logic [NPROF-1:0]        prof_arst_i,
    input  logic [NPROF-1:0]        prof_launch_rise_i,
    input  logic [NPROF-1:0]        prof_latch_rise_i,
    input  logic [SEL_W-1:0]        sel_i,
    output logic [PHASE_W-1:0]      inc_eff_o,
    output logic                    arst_o,
    output edge_sel_t               edge_o
);
    localparam int HALF = 1 << (PHASE_W - 1);

    logic [FREQ_W-1:0] inc_raw;
    logic              dbl;
    logic [FREQ_W:0]   inc_scaled;

    always_comb begin
        inc_raw            = prof_inc_i[FREQ_W-1:0];
        dbl                = prof_dbl_i[0];
        arst_o             = prof_arst_i[0];
        edge_o.launch_rise = prof_launch_rise_i[0];
        edge_o.latch_rise  = prof_latch_rise_i[0];
        for (int p = 1; p < NPROF; p++) begin
            if (sel_i == SEL_W'(p)) begin
                inc_raw            = prof_inc_i[p*FREQ_W +: FREQ_W];
                dbl                = prof_dbl_i[p];
                arst_o             = prof_arst_i[p];
                edge_o.launch_rise = prof_launch_rise_i[p];
                edge_o.latch_rise  = prof_latch_rise_i[p];
            end
        end
        inc_scaled = dbl ? {inc_raw, 1'b0} : {1'b0, inc_raw};
        if (inc_scaled > (FREQ_W+1)'(HALF))
            inc_eff_o = PHASE_W'(HALF);
        else
            inc_eff_o = inc_scaled[PHASE_W-1:0];
    end
endmodule

// File: rtl/sckgen_phase_acc.sv
module sckgen_phase_acc #(
    parameter int PHASE_W = 11
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               run_i,
    input  logic               clr_i,
    input  logic [PHASE_W-1:0] inc_i,
    output logic               ge_half_o,
    output logic               ge_full_o
);
    localparam int HALF = 1 << (PHASE_W - 1);

    logic [PHASE_W-1:0] acc_q;
    logic [PHASE_W:0]   sum;

    assign sum       = {1'b0, acc_q} + {1'b0, inc_i};
    assign ge_half_o = sum >= (PHASE_W+1)'(HALF);
    assign ge_full_o = sum[PHASE_W];

    always_ff @(posedge clk_i) begin
        if (!rst_ni || !run_i || clr_i)
            acc_q <= '0;
        else
            acc_q <= sum[PHASE_W-1:0];
    end

    AST_ZERO_INC_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !clr_i && inc_i == '0) |=> $stable(acc_q)); // R3
endmodule

// File: rtl/sckgen_edge_map.sv
module sckgen_edge_map
    import sckgen_pkg::*;
(
    input  logic      lead_i,
    input  logic      trail_i,
    input  logic      cpol_i,
    input  edge_sel_t edge_i,
    output logic      launch_o,
    output logic      sample_o
);
    logic rising;
    logic falling;

    always_comb begin
        rising   = (lead_i && !cpol_i) || (trail_i && cpol_i);
        falling  = (lead_i && cpol_i)  || (trail_i && !cpol_i);
        launch_o = edge_i.launch_rise ? rising : falling;
        sample_o = edge_i.latch_rise  ? rising : falling;
    end
endmodule

// File: rtl/sckgen_top.sv
module sckgen_top
    import sckgen_pkg::*;
#(
    parameter int NPROF   = 2,
    parameter int FREQ_W  = 16,
    parameter int PHASE_W = 11,
    parameter int SEL_W   = (NPROF > 1) ? $clog2(NPROF) : 1
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    run_i,
    input  logic                    restart_i,
    input  logic                    ss_active_i,
    input  logic                    cpol_i,
    input  logic                    gate_idle_i,
    input  logic [SEL_W-1:0]        sel_i,
    input  logic [NPROF*FREQ_W-1:0] prof_inc_i,
    input  logic [NPROF-1:0]        prof_dbl_i,
    input  logic [NPROF-1:0]        prof_arst_i,
    input  logic [NPROF-1:0]        prof_launch_rise_i,
    input  logic [NPROF-1:0]        prof_latch_rise_i,
    output logic                    sck_o,
    output logic                    launch_o,
    output logic                    sample_o
);
    localparam int HALF = 1 << (PHASE_W - 1);

    gen_state_e         state_q, state_d;
    logic [PHASE_W-1:0] inc_eff;
    logic               arst;
    edge_sel_t          edge_sel;
    logic               running, clr;
    logic               ge_half, ge_full;
    logic               lead, trail;
    logic               launch_c, sample_c;
    logic               launch_q, sample_q;

    sckgen_prof_sel #(
        .NPROF(NPROF), .FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .SEL_W(SEL_W)
    ) u_sel (
        .prof_inc_i         (prof_inc_i),
        .prof_dbl_i         (prof_dbl_i),
        .prof_arst_i        (prof_arst_i),
        .prof_launch_rise_i (prof_launch_rise_i),
        .prof_latch_rise_i  (prof_latch_rise_i),
        .sel_i              (sel_i),
        .inc_eff_o          (inc_eff),
        .arst_o             (arst),
        .edge_o             (edge_sel)
    );

    assign running = run_i && !(gate_idle_i && !ss_active_i);
    assign clr     = running && restart_i && arst;

    sckgen_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (running),
        .clr_i     (clr),
        .inc_i     (inc_eff),
        .ge_half_o (ge_half),
        .ge_full_o (ge_full)
    );

    // next-state and edge detection
    always_comb begin
        state_d = state_q;
        lead    = 1'b0;
        trail   = 1'b0;
        if (!running) begin
            state_d = GEN_IDLE;
        end else if (clr) begin
            state_d = GEN_LOW;
        end else begin
            unique case (state_q)
                GEN_IDLE, GEN_LOW: begin
                    if (ge_half) begin
                        state_d = GEN_HIGH;
                        lead    = 1'b1;
                    end else begin
                        state_d = GEN_LOW;
                    end
                end
                GEN_HIGH: begin
                    if (ge_full) begin
                        state_d = GEN_LOW;
                        trail   = 1'b1;
                    end
                end
                default: state_d = GEN_IDLE;
            endcase
        end
    end

    sckgen_edge_map u_map (
        .lead_i   (lead),
        .trail_i  (trail),
        .cpol_i   (cpol_i),
        .edge_i   (edge_sel),
        .launch_o (launch_c),
        .sample_o (sample_c)
    );

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            state_q <= GEN_IDLE;
        else
            state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            launch_q <= 1'b0;
            sample_q <= 1'b0;
        end else begin
            launch_q <= launch_c;
            sample_q <= sample_c;
        end
    end

    assign sck_o    = cpol_i ^ (state_q == GEN_HIGH);
    assign launch_o = launch_q;
    assign sample_o = sample_q;

    AST_EFF_INC_CAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inc_eff <= PHASE_W'(HALF)); // R4
    AST_STOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!run_i) |-> (!launch_o && !sample_o && state_q == GEN_IDLE)); // R5
    AST_GATED_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(gate_idle_i && !ss_active_i) |-> state_q == GEN_IDLE); // R6
    AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(clr) |-> (state_q == GEN_LOW && !launch_o && !sample_o)); // R7
    AST_STROBE_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (launch_o || sample_o) |-> (state_q != $past(state_q))); // R8
endmodule

// File: tb/sckgen_top_test.sv
module sckgen_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0, restart = 1'b0, ss = 1'b1, cpol = 1'b0, gate = 1'b0;
    logic [0:0]  sel = 1'b0;
    logic [15:0] t_inc [2];
    logic [1:0]  t_dbl = '0, t_arst = '0, t_lr = '0, t_sr = '0;
    logic        sck, launch, sample;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sckgen_top uut (
        .clk_i(clk), .rst_ni(rst_n), .run_i(run), .restart_i(restart),
        .ss_active_i(ss), .cpol_i(cpol), .gate_idle_i(gate), .sel_i(sel),
        .prof_inc_i({t_inc[1], t_inc[0]}), .prof_dbl_i(t_dbl),
        .prof_arst_i(t_arst), .prof_launch_rise_i(t_lr), .prof_latch_rise_i(t_sr),
        .sck_o(sck), .launch_o(launch), .sample_o(sample)
    );

    // arithmetic model of the requirements
    int m_acc = 0, m_ph = 0, m_e, m_nx;
    bit m_l = 0, m_s = 0, m_lead, m_trail, m_rise, m_fall;

    function automatic int eff_inc(int inc, bit dbl);
        int e = dbl ? inc * 2 : inc;
        return (e > 1024) ? 1024 : e;
    endfunction

    always @(posedge clk) begin
        m_lead = 0; m_trail = 0;
        m_e = eff_inc(int'(t_inc[sel]), t_dbl[sel]);
        if (!rst_n || !(run && !(gate && !ss))) begin
            m_acc = 0; m_ph = 0;
        end else if (restart && t_arst[sel]) begin
            m_acc = 0; m_ph = 0;
        end else begin
            m_nx = m_acc + m_e;
            if (m_ph == 0 && m_nx >= 1024) begin m_ph = 1; m_lead = 1; end
            else if (m_ph == 1 && m_nx >= 2048) begin m_ph = 0; m_trail = 1; end
            m_acc = m_nx % 2048;
        end
        m_rise = (m_lead && !cpol) || (m_trail && cpol);
        m_fall = (m_lead && cpol) || (m_trail && !cpol);
        m_l = t_lr[sel] ? m_rise : m_fall;
        m_s = t_sr[sel] ? m_rise : m_fall;
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic chk_all(string req);
        chk(req, "sck", int'(sck), int'(cpol) ^ m_ph);
        chk("R8", "launch", int'(launch), int'(m_l));
        chk("R8", "sample", int'(sample), int'(m_s));
    endtask

    function automatic int inc_at(int i);
        case (i)
            0: return 0;     1: return 1;     2: return 3;    3: return 100;
            4: return 256;   5: return 512;   6: return 700;  7: return 1000;
            8: return 1024;  9: return 1500;  default: return 65535;
        endcase
    endfunction

    task automatic count_run(int inc, bit dbl, int ncyc, string req);
        int tog = 0;
        logic prev;
        @(negedge clk);
        run = 0; sel = 1'b1; t_inc[1] = 16'(inc); t_inc[0] = 16'd0;
        t_dbl = {dbl, 1'b0}; gate = 0; restart = 0;
        @(negedge clk);
        prev = sck; run = 1;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            if (sck != prev) tog++;
            prev = sck;
        end
        chk(req, "toggle count", tog, (ncyc * eff_inc(inc, dbl)) / 1024);
        run = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_inc[0] = 16'd0; t_inc[1] = 16'd0;
        cpol = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "sck in reset", int'(sck), 1);
        chk("R1", "launch in reset", int'(launch), 0);
        chk("R1", "sample in reset", int'(sample), 0);
        rst_n = 1'b1;
        cpol = 1'b0;

        // R2 / R10: toggle counts on profile 1 with profile 0 silent
        count_run(100, 0, 256, "R2 R10");
        count_run(300, 1, 200, "R2");
        count_run(0, 0, 100, "R3");
        count_run(65535, 0, 20, "R4");
        count_run(600, 1, 20, "R4");

        // R5: stop returns to idle
        @(negedge clk); run = 1;
        repeat (3) @(negedge clk);
        run = 0;
        @(negedge clk);
        chk("R5", "sck after stop", int'(sck), int'(cpol));

        // sweep
        for (int ii = 0; ii < 11; ii++)
        for (int cp = 0; cp < 2; cp++)
        for (int ed = 0; ed < 4; ed++)
        for (int db = 0; db < 2; db++) begin
            int k = ((ii * 2 + cp) * 4 + ed) * 2 + db;
            @(negedge clk);
            run = 0; restart = 0; ss = 1;
            cpol = cp[0]; gate = k[1]; sel = k[0];
            t_inc[sel]  = 16'(inc_at(ii));
            t_inc[!sel] = 16'(inc_at(10 - ii) + 7);
            t_dbl  = sel ? {db[0], !db[0]} : {!db[0], db[0]};
            t_arst = sel ? {ed[0], !ed[0]} : {!ed[0], ed[0]};
            t_lr   = sel ? {ed[1], !ed[1]} : {!ed[1], ed[1]};
            t_sr   = sel ? {ed[0], !ed[0]} : {!ed[0], ed[0]};
            @(negedge clk);
            chk_all("R5");
            run = 1;
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (c == 18)                 chk_all("R7");
                else if (c >= 26 && c < 31)  chk_all("R6");
                else if (inc_at(ii) == 0)    chk_all("R3");
                else if (eff_inc(inc_at(ii), db[0]) == 1024) chk_all("R4");
                else                         chk_all("R9");
                restart = (c == 17);
                ss = !(c >= 25 && c < 30);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule